// File: doc/BRIEF.md
# Polynomial Inner-Product Sequencer

This controller orders the work of one inner product of two polynomial vectors, C = INTT(Σ NTT(a_i) ∘ NTT(b_i)), for a vector length k of 2, 3 or 4. It does no arithmetic. It commands two external engines through start/done handshakes. The transform engine performs forward and inverse NTT passes. The multiply-accumulate engine performs coefficient-wise modular multiplies and adds. Each command names the storage slots that the engine reads and writes. Every intermediate result stays in scratchpad slots. Coefficients cross the bus only twice: when the CPU loads the 2k inputs into the staging buffer, and when it reads the final polynomial back from that buffer.

A CPU controls the block through three 64-bit registers using plain loads and stores. It writes a start bit together with the vector length. It then polls a status word until the done bit appears. A cycle counter reports how long the last run kept the block busy.

Top module: `polyvec_seq`

## Requirements
- R1: After reset, STATUS and CYCLES read as zero, and no engine start is issued.
- R2: The register offsets are 0x00 for CTRL, 0x08 for STATUS and 0x10 for CYCLES. A read returns its data on the cycle after the read strobe. STATUS has busy in bit 0, done in bit 1 and error in bit 2. CTRL bits 3:2 hold the length code, where k equals code plus 2. A CTRL read returns the code of the last accepted run in bits 3:2.
- R3: Writing CTRL bit 0 = 1 while idle, with a code of 0 to 2, starts a run. The start sets busy and clears done and error.
- R4: A run first issues 2k forward transforms, for p = 0 up to 2k−1. Each one reads staging entry p and writes scratchpad slot p. Input a_i sits at entry 2i and input b_i sits at entry 2i+1.
- R5: After the transforms, the block issues k multiplies in ascending i. Multiply i reads slots 2i and 2i+1 and writes slot 8+i.
- R6: After the multiplies, the block issues exactly k−1 add passes. The first adds slot 8 to slot 9 into slot 12. Add pass j, for j of 2 or more, adds slot 12 to slot 8+j into slot 12.
- R7: After the adds, the block issues exactly one inverse transform. It reads slot 12 and writes staging entry 0.
- R8: Only one command is outstanding at a time. The next command is issued only after the done pulse of the engine that holds the current command.
- R9: When the inverse transform completes, busy clears and done sets. Done then stays set until the next accepted start.
- R10: A start written while busy sets error and leaves the running schedule and the cycle count unchanged.
- R11: A start written while idle with code 3 (k = 5) sets error. It issues no command, leaves busy clear and leaves done as it was.
- R12: CYCLES clears on an accepted start and counts every cycle that busy is set. It holds its value after the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid one cycle after bus_re |
| xf_start | output | 1 | One-cycle command pulse to the transform engine |
| xf_inv | output | 1 | 1 selects the inverse transform |
| xf_src | output | SLOT_W | Source slot, or staging entry for a forward transform |
| xf_dst | output | SLOT_W | Destination slot, or staging entry for the inverse transform |
| xf_done | input | 1 | Transform engine completion pulse |
| mac_start | output | 1 | One-cycle command pulse to the multiply-accumulate engine |
| mac_add | output | 1 | 0 selects multiply, 1 selects add |
| mac_srca | output | SLOT_W | First operand slot |
| mac_srcb | output | SLOT_W | Second operand slot |
| mac_dst | output | SLOT_W | Result slot |
| mac_done | input | 1 | Multiply-accumulate engine completion pulse |

## Verification
The assertions assume that each engine answers a command with exactly one done pulse, at the earliest on the cycle after its start. They also assume that no done pulse arrives while the block is waiting on the other engine. The bench keeps within these limits. Its two responders log each command at a falling edge and raise done a fixed number of cycles later: three cycles for transforms and two for multiply-accumulate. It then compares the logged command sequence against a sequence rebuilt from the slot rules. The bench drives register accesses only at falling edges, so a write to CTRL while busy is the only overlap it creates, and it creates that overlap on purpose.

// File: rtl/polyvec_pkg.sv
package polyvec_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FWD,
    PH_MUL,
    PH_ADD,
    PH_INV
  } phase_e;
endpackage

// File: rtl/polyvec_csr.sv
module polyvec_csr #(
  parameter int KMAX   = 4,
  parameter int ADDR_W = 5,
  parameter int CYC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  input  logic              busy,
  input  logic              done,
  output logic              go,
  output logic [1:0]        kcode,
  output logic [63:0]       bus_rdata
);
  localparam int RW = ADDR_W - 3;

  logic [RW-1:0]    reg_sel;
  logic             wr_start;
  logic             k_ok;
  logic             err_q;
  logic [1:0]       kcode_q;
  logic [CYC_W-1:0] cycles_q;
  logic             unused_bits;

  assign reg_sel  = bus_addr[ADDR_W-1:3];
  assign kcode    = bus_wdata[3:2];
  assign wr_start = bus_we && (reg_sel == '0) && bus_wdata[0];
  assign k_ok     = (32'(kcode) + 32'd2) <= 32'(KMAX);
  assign go       = wr_start && !busy && k_ok;
  assign unused_bits = ^{bus_addr[2:0], bus_wdata[63:4], bus_wdata[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q    <= 1'b0;
      kcode_q  <= '0;
      cycles_q <= '0;
    end else begin
      if (go) begin
        err_q    <= 1'b0;
        kcode_q  <= kcode;
        cycles_q <= '0;
      end else begin
        if (wr_start) err_q <= 1'b1;
        if (busy) cycles_q <= cycles_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (reg_sel)
        RW'(0):  bus_rdata <= {60'd0, kcode_q, 2'b00};
        RW'(1):  bus_rdata <= {61'd0, err_q, done, busy};
        RW'(2):  bus_rdata <= 64'(cycles_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_start && busy) |=> err_q);
  p_bad_code_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_start && !busy && !k_ok) |=> (err_q && !busy));
  p_cycle_step_r12: assert property (@(posedge clk) disable iff (rst)
    (busy && !go) |=> (cycles_q == $past(cycles_q) + 1'b1));
endmodule

// File: rtl/polyvec_sched.sv
module polyvec_sched
  import polyvec_pkg::*;
#(
  parameter int KMAX   = 4,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [1:0]        kcode,
  input  logic              xf_done,
  input  logic              mac_done,
  output logic              busy,
  output logic              done,
  output logic              xf_start,
  output logic              xf_inv,
  output logic [SLOT_W-1:0] xf_src,
  output logic [SLOT_W-1:0] xf_dst,
  output logic              mac_start,
  output logic              mac_add,
  output logic [SLOT_W-1:0] mac_srca,
  output logic [SLOT_W-1:0] mac_srcb,
  output logic [SLOT_W-1:0] mac_dst
);
  localparam int KW = $clog2(KMAX + 1);
  localparam logic [SLOT_W-1:0] PROD_BASE = SLOT_W'(2 * KMAX);
  localparam logic [SLOT_W-1:0] SUM_SLOT  = SLOT_W'(3 * KMAX);

  phase_e        phase_q;
  logic [KW-1:0] k_q;
  logic [KW:0]   idx_q;
  logic [KW:0]   nidx;
  logic [KW:0]   last_fwd;
  logic [KW:0]   last_k;
  logic [KW-1:0] n_add_q;

  assign nidx     = idx_q + 1'b1;
  assign last_fwd = {k_q, 1'b0} - 1'b1;
  assign last_k   = {1'b0, k_q} - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      k_q       <= '0;
      idx_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      xf_start  <= 1'b0;
      xf_inv    <= 1'b0;
      xf_src    <= '0;
      xf_dst    <= '0;
      mac_start <= 1'b0;
      mac_add   <= 1'b0;
      mac_srca  <= '0;
      mac_srcb  <= '0;
      mac_dst   <= '0;
    end else begin
      xf_start  <= 1'b0;
      mac_start <= 1'b0;
      case (phase_q)
        PH_IDLE: if (go) begin
          k_q      <= KW'(kcode) + KW'(2);
          idx_q    <= '0;
          busy     <= 1'b1;
          done     <= 1'b0;
          phase_q  <= PH_FWD;
          xf_start <= 1'b1;
          xf_inv   <= 1'b0;
          xf_src   <= '0;
          xf_dst   <= '0;
        end
        PH_FWD: if (xf_done) begin
          if (idx_q == last_fwd) begin
            phase_q   <= PH_MUL;
            idx_q     <= '0;
            mac_start <= 1'b1;
            mac_add   <= 1'b0;
            mac_srca  <= '0;
            mac_srcb  <= SLOT_W'(1);
            mac_dst   <= PROD_BASE;
          end else begin
            idx_q    <= nidx;
            xf_start <= 1'b1;
            xf_src   <= SLOT_W'(nidx);
            xf_dst   <= SLOT_W'(nidx);
          end
        end
        PH_MUL: if (mac_done) begin
          mac_start <= 1'b1;
          if (idx_q == last_k) begin
            phase_q  <= PH_ADD;
            idx_q    <= (KW+1)'(1);
            mac_add  <= 1'b1;
            mac_srca <= PROD_BASE;
            mac_srcb <= PROD_BASE + 1'b1;
            mac_dst  <= SUM_SLOT;
          end else begin
            idx_q    <= nidx;
            mac_srca <= SLOT_W'({nidx, 1'b0});
            mac_srcb <= SLOT_W'({nidx, 1'b1});
            mac_dst  <= PROD_BASE + SLOT_W'(nidx);
          end
        end
        PH_ADD: if (mac_done) begin
          if (idx_q == last_k) begin
            phase_q  <= PH_INV;
            xf_start <= 1'b1;
            xf_inv   <= 1'b1;
            xf_src   <= SUM_SLOT;
            xf_dst   <= '0;
          end else begin
            idx_q     <= nidx;
            mac_start <= 1'b1;
            mac_srca  <= SUM_SLOT;
            mac_srcb  <= PROD_BASE + SLOT_W'(nidx);
            mac_dst   <= SUM_SLOT;
          end
        end
        PH_INV: if (xf_done) begin
          phase_q <= PH_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || go) n_add_q <= '0;
    else if (mac_start && mac_add) n_add_q <= n_add_q + 1'b1;
  end

  p_excl_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    !(xf_start && mac_start));
  p_single_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    (xf_start || mac_start) |=> !(xf_start || mac_start));
  p_inv_after_adds_r7: assert property (@(posedge clk) disable iff (rst)
    (xf_start && xf_inv) |-> (n_add_q == k_q - 1'b1));
  p_finish_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/polyvec_seq.sv
module polyvec_seq #(
  parameter int KMAX   = 4,
  parameter int ADDR_W = 5,
  parameter int CYC_W  = 32,
  parameter int SLOT_W = $clog2(3 * KMAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              xf_start,
  output logic              xf_inv,
  output logic [SLOT_W-1:0] xf_src,
  output logic [SLOT_W-1:0] xf_dst,
  input  logic              xf_done,
  output logic              mac_start,
  output logic              mac_add,
  output logic [SLOT_W-1:0] mac_srca,
  output logic [SLOT_W-1:0] mac_srcb,
  output logic [SLOT_W-1:0] mac_dst,
  input  logic              mac_done
);
  logic       go;
  logic [1:0] kcode;
  logic       busy;
  logic       done;

  polyvec_csr #(.KMAX(KMAX), .ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_csr (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .done(done),
    .go(go), .kcode(kcode), .bus_rdata(bus_rdata)
  );

  polyvec_sched #(.KMAX(KMAX), .SLOT_W(SLOT_W)) u_sched (
    .clk(clk), .rst(rst), .go(go), .kcode(kcode),
    .xf_done(xf_done), .mac_done(mac_done), .busy(busy), .done(done),
    .xf_start(xf_start), .xf_inv(xf_inv), .xf_src(xf_src), .xf_dst(xf_dst),
    .mac_start(mac_start), .mac_add(mac_add), .mac_srca(mac_srca),
    .mac_srcb(mac_srcb), .mac_dst(mac_dst)
  );

  p_done_expected_r8: assert property (@(posedge clk) disable iff (rst)
    (xf_done || mac_done) |-> busy);
endmodule

// File: tb/polyvec_seq_bench.sv
module polyvec_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        xf_start, xf_inv, mac_start, mac_add;
  logic [3:0]  xf_src, xf_dst, mac_srca, mac_srcb, mac_dst;
  logic        xf_done = 1'b0;
  logic        mac_done = 1'b0;

  always #10 clk = ~clk;

  polyvec_seq u_polyvec_seq (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xf_start(xf_start), .xf_inv(xf_inv), .xf_src(xf_src), .xf_dst(xf_dst),
    .xf_done(xf_done), .mac_start(mac_start), .mac_add(mac_add),
    .mac_srca(mac_srca), .mac_srcb(mac_srcb), .mac_dst(mac_dst),
    .mac_done(mac_done)
  );

  // Table entries: {length code[7:6], expected busy cycles[5:0]}.
  // The cycle counts use 3-cycle transforms and 2-cycle MACs: 10k+1.
  localparam logic [7:0] VEC [0:3] = '{8'h15, 8'h5F, 8'hA9, 8'h15};

  int errors = 0;
  int checks = 0;
  int nlog = 0;
  bit finished = 0;
  logic [13:0] cmd_log [0:31];
  logic [63:0] rd;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Command code {kind, a, b, dst}: kind 0 fwd, 1 mul, 2 add, 3 inverse.
  function automatic logic [13:0] exp_cmd(input int k, input int n);
    int i;
    if (n < 2*k) return {2'd0, 4'(n), 4'd0, 4'(n)};
    if (n < 3*k) begin
      i = n - 2*k;
      return {2'd1, 4'(2*i), 4'(2*i+1), 4'(8+i)};
    end
    if (n < 4*k-1) begin
      i = n - 3*k + 1;
      return {2'd2, (i == 1) ? 4'd8 : 4'd12, 4'(8+i), 4'd12};
    end
    return {2'd3, 4'd12, 4'd0, 4'd0};
  endfunction

  initial begin : xf_responder
    int pend = 0;
    forever begin
      @(negedge clk);
      xf_done = 1'b0;
      if (xf_start) begin
        if (nlog < 32) cmd_log[nlog] = {xf_inv ? 2'd3 : 2'd0, xf_src, 4'd0, xf_dst};
        nlog++;
        pend = 2;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) xf_done = 1'b1;
      end
    end
  end

  initial begin : mac_responder
    int pend = 0;
    forever begin
      @(negedge clk);
      mac_done = 1'b0;
      if (mac_start) begin
        if (nlog < 32) cmd_log[nlog] = {mac_add ? 2'd2 : 2'd1, mac_srca, mac_srcb, mac_dst};
        nlog++;
        pend = 1;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) mac_done = 1'b1;
      end
    end
  end

  task automatic bus_write(input logic [4:0] addr, input logic [63:0] data);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] addr, output logic [63:0] data);
    bus_re = 1'b1; bus_addr = addr;
    @(negedge clk);
    bus_re = 1'b0;
    data = bus_rdata;
  endtask

  task automatic check_log(input int k);
    check("R4-R7 command count", 64'(nlog), 64'(4*k));
    for (int n = 0; n < 4*k && n < 32; n++) begin
      if (n < 2*k)      check("R4 forward order", 64'(cmd_log[n]), 64'(exp_cmd(k, n)));
      else if (n < 3*k) check("R5 multiply order", 64'(cmd_log[n]), 64'(exp_cmd(k, n)));
      else if (n < 4*k-1) check("R6 add pass", 64'(cmd_log[n]), 64'(exp_cmd(k, n)));
      else              check("R7 inverse last", 64'(cmd_log[n]), 64'(exp_cmd(k, n)));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    bus_read(5'h08, rd); check("R1 status after reset", rd, 64'd0);
    bus_read(5'h10, rd); check("R1 cycles after reset", rd, 64'd0);
    check("R1 no start after reset", 64'(nlog), 64'd0);

    foreach (VEC[v]) begin
      int k;
      k = int'(VEC[v][7:6]) + 2;
      nlog = 0;
      bus_write(5'h00, {60'd0, VEC[v][7:6], 2'b01});
      bus_read(5'h08, rd); check("R3 busy after start", rd, 64'd1);
      repeat (10*k + 4) @(negedge clk);
      bus_read(5'h08, rd); check("R9 done after run", rd, 64'd2);
      bus_read(5'h10, rd); check("R12 busy cycles", rd, 64'(VEC[v][5:0]));
      bus_read(5'h00, rd); check("R2 ctrl readback", rd, 64'({VEC[v][7:6], 2'b00}));
      check_log(k);
    end

    // R9: done held, R12: cycles held
    repeat (30) @(negedge clk);
    bus_read(5'h08, rd); check("R9 done holds", rd, 64'd2);
    bus_read(5'h10, rd); check("R12 cycles hold", rd, 64'd21);

    // R10: start while busy is rejected
    nlog = 0;
    bus_write(5'h00, 64'h9);
    repeat (5) @(negedge clk);
    bus_write(5'h00, 64'h1);
    bus_read(5'h08, rd); check("R10 error while busy", rd, 64'd5);
    repeat (50) @(negedge clk);
    bus_read(5'h08, rd); check("R10 run completes, error kept", rd, 64'd6);
    bus_read(5'h10, rd); check("R10 cycles unchanged", rd, 64'd41);
    check_log(4);

    // R11: code 3 rejected while idle
    nlog = 0;
    bus_write(5'h00, 64'hD);
    bus_read(5'h08, rd); check("R11 error, idle, done kept", rd, 64'd6);
    repeat (20) @(negedge clk);
    check("R11 no command issued", 64'(nlog), 64'd0);
    bus_read(5'h00, rd); check("R11 ctrl code unchanged", rd, 64'h8);

    // R3: accepted start clears error and done
    nlog = 0;
    bus_write(5'h00, 64'h1);
    bus_read(5'h08, rd); check("R3 start clears flags", rd, 64'd1);
    repeat (30) @(negedge clk);
    bus_read(5'h08, rd); check("R9 done after final run", rd, 64'd2);
    check_log(2);

    finish_run();
  end
endmodule